// File: doc/BRIEF.md
# NAND Flash Hamming Parity Accumulator

This block watches the data bytes that pass between a host and an 8-bit NAND device. It folds each byte into a running set of paired line parities. From these parities software can later locate and repair a single flipped bit within a 512-byte block. One accumulator serves each of four chip-select lanes.

A lane accumulates a byte only when both its NAND mode and its ECC enable are on. Each byte is folded into two kinds of parity. The first kind covers bit columns within the byte. The second kind covers rows chosen by the byte's position in the block. Writing a 1 to a lane's ECC enable bit empties that lane and restarts its byte count at zero.

For a read, software picks a lane and reads the 32-bit result word. To find a single-bit error, it compares the stored word with the word computed on read-back. The odd half of their XOR then gives the byte index and bit number of the flipped bit.

Top module: `nand_ecc_accum`

## Requirements
- R1: After a synchronous active-low reset, the result word of every lane reads 0.
- R2: The result word holds the 12 odd parities in bits 27:16 and the 12 even parities in bits 11:0. Bit 16+j and bit j belong to parity level j. All other bits read 0.
- R3: Levels 0, 1 and 2 are column parities over the bits of each byte. For bit position b, the odd member of level j covers the bits where b[j] is 1, and the even member covers the bits where b[j] is 0. So P1 even is bit 0 ^ bit 2 ^ bit 4 ^ bit 6, and P4 even is bits 0 to 3.
- R4: Level 3+k (k from 0 to 8) is a row parity taken over whole bytes. The parity of a byte goes to the odd member when bit k of the lane's byte index is 1, and to the even member otherwise. The byte index starts at 0 and rises by one for each byte accumulated.
- R5: A byte with xfer_valid=1 on lane xfer_cs accumulates only when both ctrl bit 8+cs (ECC enable) and ctrl bit cs (NAND mode) are set. Lane 0 maps to chip select 2, and lane 3 maps to chip select 5. In all other cases the lane's word and index are left unchanged.
- R6: A control write with bit 8+i set clears lane i's parities and resets its byte index to 0. A byte offered to that lane in the same cycle is dropped.
- R7: The byte index wraps from 511 to 0, so byte 512 after a clear is treated as byte 0.
- R8: Over a full 512-byte block, the word equals the XOR of the contributions of every set data bit.
- R9: Suppose two blocks differ in one bit, at byte n and bit b. Then the XOR of their odd halves equals {n,b}, and the XOR of their even halves equals the bitwise inverse of {n,b}, 12 bits wide.
- R10: Bytes and control writes aimed at one lane leave the words of the other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 12 | Bits 11:8 are the ECC enables and bits 3:0 the NAND modes of lanes 3..0 |
| xfer_valid | input | 1 | A data byte is on the bus this cycle |
| xfer_cs | input | 2 | Lane of the byte (0 = chip select 2) |
| xfer_data | input | 8 | Snooped data byte |
| rd_sel | input | 2 | Lane whose result is shown |
| rd_word | output | 32 | Result word of the selected lane |

## Verification
The hardest conditions to reach from the ports are a clear that lands in the same cycle as a byte, and a byte index that wraps past 511. The bench drives a control write and a byte on the same falling edge to create the first. It streams a full 512 zero bytes, then one marker byte, to create the second. The bench also checks the single-flip syndrome. It recomputes each random block with exactly one bit toggled and takes the XOR of the two words the design reports.

// File: rtl/nand_ecc_pkg.sv
// Shared sizing for the NAND parity accumulator.
// Assumes 8-bit data bytes, so three column levels are fixed.
package nand_ecc_pkg;
    localparam int COL_LEVELS = 3;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 32;
    localparam int ODD_LSB    = 16;
endpackage

// File: rtl/nand_ecc_step.sv
// Combinational fold of one byte into the even/odd parity vectors.
// Assumes the caller supplies the byte's index within the block.
module nand_ecc_step
    import nand_ecc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic [BYTE_W-1:0]             data,
    input  logic [IDX_W-1:0]              idx,
    input  logic [COL_LEVELS+IDX_W-1:0]   even_in,
    input  logic [COL_LEVELS+IDX_W-1:0]   odd_in,
    output logic [COL_LEVELS+IDX_W-1:0]   even_out,
    output logic [COL_LEVELS+IDX_W-1:0]   odd_out
);
    localparam int LEVELS = COL_LEVELS + IDX_W;

    logic byte_par;
    logic [LEVELS-1:0] even_hit, odd_hit;

    assign byte_par = ^data;

    genvar j, b;
    generate
        for (j = 0; j < COL_LEVELS; j++) begin : g_col
            logic [BYTE_W-1:0] m_odd;
            for (b = 0; b < BYTE_W; b++) begin : g_bit
                assign m_odd[b] = ((b >> j) & 1) != 0;
            end
            assign odd_hit[j]  = ^(data & m_odd);
            assign even_hit[j] = ^(data & ~m_odd);
        end
        for (j = 0; j < IDX_W; j++) begin : g_row
            assign odd_hit[COL_LEVELS+j]  = byte_par & idx[j];
            assign even_hit[COL_LEVELS+j] = byte_par & ~idx[j];
        end
    endgenerate

    assign even_out = even_in ^ even_hit;
    assign odd_out  = odd_in ^ odd_hit;
endmodule

// File: rtl/nand_ecc_lane.sv
// One lane: parity registers plus byte index, with clear priority.
// Assumes clr and take are single-cycle qualified strobes.
module nand_ecc_lane
    import nand_ecc_pkg::*;
#(
    parameter int IDX_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              take,
    input  logic [BYTE_W-1:0] data,
    output logic [WORD_W-1:0] word
);
    localparam int LEVELS = COL_LEVELS + IDX_W;

    logic [LEVELS-1:0] even_q, odd_q, even_d, odd_d;
    logic [IDX_W-1:0]  idx_q;

    nand_ecc_step #(.IDX_W(IDX_W)) u_step (
        .data(data), .idx(idx_q),
        .even_in(even_q), .odd_in(odd_q),
        .even_out(even_d), .odd_out(odd_d)
    );

    // Parity and index state update; clear wins over an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            even_q <= '0;
            odd_q  <= '0;
            idx_q  <= '0;
        end else if (take) begin
            even_q <= even_d;
            odd_q  <= odd_d;
            idx_q  <= idx_q + 1'b1;
        end
    end

    // Pack the two parity halves into the result word.
    always_comb begin
        word = '0;
        word[LEVELS-1:0]                 = even_q;
        word[ODD_LSB+LEVELS-1:ODD_LSB]   = odd_q;
    end

    // R6
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (word == '0 && idx_q == '0));
    // R4
    index_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !clr) |=> idx_q == $past(idx_q) + 1'b1);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !clr) |=> ($stable(word) && $stable(idx_q)));
endmodule

// File: rtl/nand_ecc_accum.sv
// Top: control register, lane qualification and result readout.
// Assumes one snooped byte per cycle at most, on one lane.
module nand_ecc_accum
    import nand_ecc_pkg::*;
#(
    parameter int CS_N  = 4,
    parameter int IDX_W = 9,
    localparam int CS_W   = $clog2(CS_N),
    localparam int CTRL_W = 8 + CS_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              xfer_valid,
    input  logic [CS_W-1:0]   xfer_cs,
    input  logic [BYTE_W-1:0] xfer_data,
    input  logic [CS_W-1:0]   rd_sel,
    output logic [WORD_W-1:0] rd_word
);
    logic [CS_N-1:0]   ecc_en_q, nand_en_q;
    logic [WORD_W-1:0] lane_word [CS_N];

    // Control register holding per-lane ECC enables and NAND modes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ecc_en_q  <= '0;
            nand_en_q <= '0;
        end else if (ctrl_we) begin
            ecc_en_q  <= ctrl_wdata[8 +: CS_N];
            nand_en_q <= ctrl_wdata[0 +: CS_N];
        end
    end

    genvar i;
    generate
        for (i = 0; i < CS_N; i++) begin : g_lane
            logic clr_i, take_i;
            assign clr_i  = ctrl_we && ctrl_wdata[8+i];
            assign take_i = xfer_valid && (xfer_cs == CS_W'(i))
                            && ecc_en_q[i] && nand_en_q[i];
            nand_ecc_lane #(.IDX_W(IDX_W)) u_lane (
                .clk(clk), .rst_n(rst_n), .clr(clr_i), .take(take_i),
                .data(xfer_data), .word(lane_word[i])
            );
        end
    endgenerate

    // Result readout of the selected lane.
    assign rd_word = lane_word[rd_sel];

    // R2
    spare_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_word[31:28] == 4'h0 && rd_word[15:12] == 4'h0));
endmodule

// File: tb/nand_ecc_accum_bench.sv
module nand_ecc_accum_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {data, expected word for a single byte at index 0}
    localparam logic [39:0] VECS [NVEC] = '{
        {8'h01, 32'h00000FFF}, {8'h80, 32'h00070FF8}, {8'h03, 32'h00010001},
        {8'h00, 32'h00000000}, {8'hFF, 32'h00000000}, {8'h10, 32'h00040FFB}
    };

    logic clk = 0, rst_n = 0;
    logic ctrl_we = 0;
    logic [11:0] ctrl_wdata = '0;
    logic xfer_valid = 0;
    logic [1:0] xfer_cs = '0, rd_sel = '0;
    logic [7:0] xfer_data = '0;
    logic [31:0] rd_word;

    int checks = 0, errors = 0;
    logic [7:0] blk [512];

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_accum u_nand_ecc_accum (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .xfer_valid(xfer_valid), .xfer_cs(xfer_cs), .xfer_data(xfer_data),
        .rd_sel(rd_sel), .rd_word(rd_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [11:0] v);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 0;
    endtask

    task automatic send(input logic [1:0] cs, input logic [7:0] d);
        @(negedge clk); xfer_valid = 1; xfer_cs = cs; xfer_data = d;
        @(negedge clk); xfer_valid = 0;
    endtask

    task automatic send_block(input logic [1:0] cs);
        for (int n = 0; n < 512; n++) begin
            @(negedge clk); xfer_valid = 1; xfer_cs = cs; xfer_data = blk[n];
        end
        @(negedge clk); xfer_valid = 0;
    endtask

    task automatic read(input logic [1:0] sel, output logic [31:0] w);
        rd_sel = sel; #1; w = rd_word;
    endtask

    // Position-based model: each set bit at {n,b} toggles odd or even per level.
    function automatic logic [31:0] model();
        logic [11:0] ev = '0, od = '0;
        for (int n = 0; n < 512; n++)
            for (int b = 0; b < 8; b++)
                if (blk[n][b]) begin
                    logic [11:0] pos = {n[8:0], b[2:0]};
                    for (int j = 0; j < 12; j++)
                        if (pos[j]) od[j] = ~od[j]; else ev[j] = ~ev[j];
                end
        return {4'h0, od, 4'h0, ev};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] w, w1, w2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state on every lane
        for (int s = 0; s < 4; s++) begin read(s[1:0], w); check("R1 reset", w, 32'h0); end

        // R2 R3 table walk: single byte at index 0 on lane 1
        for (int v = 0; v < NVEC; v++) begin
            ctrl_write(12'h202);
            send(2'd1, VECS[v][39:32]);
            read(2'd1, w); check("R2/R3 table", w, VECS[v][31:0]);
        end

        // R4 second byte uses index 1
        ctrl_write(12'h202); send(2'd1, 8'h00); send(2'd1, 8'h01);
        read(2'd1, w); check("R4 index1", w, 32'h00080FF7);

        // R5 ECC off (nand only, no clear) keeps word
        ctrl_write(12'h002); send(2'd1, 8'h55);
        read(2'd1, w); check("R5 ecc off", w, 32'h00080FF7);
        // R5 NAND mode off: ecc bit write clears, byte ignored
        ctrl_write(12'h200); send(2'd1, 8'h01);
        read(2'd1, w); check("R5 nand off", w, 32'h0);

        // R10 byte to lane 2 does not affect lane 1
        ctrl_write(12'h202); send(2'd1, 8'h01); send(2'd2, 8'h01);
        read(2'd1, w); check("R10 lane1 kept", w, 32'h00000FFF);
        read(2'd2, w); check("R10 lane2 off", w, 32'h0);
        // R10 clear of lane 0 leaves lane 1 word
        ctrl_write(12'h103); read(2'd1, w); check("R10 other clear", w, 32'h00000FFF);

        // R6 clear and byte in same cycle: byte dropped, index restarts
        ctrl_write(12'h202); send(2'd1, 8'h01);
        @(negedge clk); ctrl_we = 1; ctrl_wdata = 12'h202;
        xfer_valid = 1; xfer_cs = 2'd1; xfer_data = 8'h01;
        @(negedge clk); ctrl_we = 0; xfer_valid = 0;
        read(2'd1, w); check("R6 same-cycle clear", w, 32'h0);
        send(2'd1, 8'h01); read(2'd1, w); check("R6 index restart", w, 32'h00000FFF);

        // R7 wrap after 512 bytes
        ctrl_write(12'h202);
        for (int n = 0; n < 512; n++) blk[n] = 8'h00;
        send_block(2'd1); send(2'd1, 8'h80);
        read(2'd1, w); check("R7 wrap", w, 32'h00070FF8);

        // R8 R9 random blocks on lane 3, then single flip
        for (int t = 0; t < 3; t++) begin
            int fn, fb;
            for (int n = 0; n < 512; n++) blk[n] = 8'($urandom);
            ctrl_write(12'h808); send_block(2'd3);
            read(2'd3, w1); check("R8 random block", w1, model());
            fn = $urandom % 512; fb = $urandom % 8;
            blk[fn][fb] = ~blk[fn][fb];
            ctrl_write(12'h808); send_block(2'd3);
            read(2'd3, w2); check("R8 flipped block", w2, model());
            check("R9 syndrome odd", {20'h0, w1[27:16] ^ w2[27:16]},
                  {20'h0, fn[8:0], fb[2:0]});
            check("R9 syndrome even", {20'h0, w1[11:0] ^ w2[11:0]},
                  {20'h0, ~{fn[8:0], fb[2:0]}});
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule